// File: doc/BRIEF.md
# Subvector Swizzle Move Unit

This block performs a swizzled move across a vector of packed subvectors held in a small internal register file of 32-bit single-precision element slots. A 12-bit swizzle immediate carries one 3-bit selector per destination lane. For every lane of every subvector, the selector does one of three things: it copies a chosen source lane, it injects the constant 0.0 or 1.0, or it leaves the destination element as it was. The selector field therefore doubles as a built-in write mask.

A caller sets the destination base register, the source base register, the subvector length (1 to 4 lanes), the vector length (1 to 8 subvectors) and the swizzle immediate. It then pulses `start`. The unit walks the subvectors in order. For each one it first gathers every source lane into a lane buffer (state GATHER, one lane per cycle). It then scatters the results into the destination (state SCATTER, one lane per cycle). Because all reads of a subvector finish before its first write, in-place reordering is correct when source and destination overlap. After the last subvector the unit spends one cycle in DONE, where it raises `done`, and then returns to IDLE. A test port reads the register file at any time and writes it while the unit is idle.

The states and transitions are as follows:
- IDLE goes to GATHER on `start`.
- GATHER stays in GATHER until the last lane, then goes to SCATTER.
- SCATTER stays in SCATTER until the last lane. It then goes to GATHER for the next subvector, or to DONE after the last subvector.
- DONE always goes to IDLE.

Top module: `swz_move_unit`

## Requirements
- R1: After reset, `busy` and `done` are low and every one of the 64 registers reads 0x00000000 through the test port.
- R2: A test-port write lands only while the unit is idle (neither `busy` nor `done`). A write attempted during an operation leaves the register unchanged. The test read data always shows the addressed register, combinationally.
- R3: A selector value of 0 to 3 copies register (rs1 + i*L + sel) mod 64 into the destination lane. Here i is the subvector index, counted from 0, and L is the subvector length.
- R4: A selector value of 4 writes 0x00000000 (0.0) into the destination lane.
- R5: A selector value of 5 writes 0x3F800000 (1.0) into the destination lane.
- R6: Selector values 6 and 7 write nothing, and the destination register keeps its value.
- R7: The selector for lane s sits at swizzle bits [3s+2:3s]. Selectors for lanes s ≥ L have no effect.
- R8: Destination lane s of subvector i is register (rd + i*L + s) mod 64, and all index arithmetic wraps modulo 64.
- R9: All source lanes of a subvector are read before any lane of that subvector is written, so overlapping in-place moves use the pre-move values.
- R10: After `start` is taken in IDLE, `busy` is high for exactly 2*L*V cycles, where V is the vector length. `done` is then high for one cycle with `busy` low, and the unit is idle the cycle after. A `start` pulse while the unit is busy is ignored.
- R11: The configuration inputs are captured when `start` is taken, so changes to them during an operation have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only in IDLE) |
| cfg_rd | input | 6 | Destination base register |
| cfg_rs1 | input | 6 | Source base register |
| cfg_subvl | input | 3 | Subvector length, 1 to 4 |
| cfg_vl | input | 4 | Vector length in subvectors, 1 to 8 |
| cfg_swizzle | input | 12 | Four 3-bit lane selectors |
| busy | output | 1 | High in GATHER and SCATTER |
| done | output | 1 | One-cycle completion pulse (DONE state) |
| tp_we | input | 1 | Test-port write enable |
| tp_addr | input | 6 | Test-port register index |
| tp_wdata | input | 32 | Test-port write data |
| tp_rdata | output | 32 | Test-port read data |

## Verification
The main function is exercised with several swizzle patterns:
- An identity swizzle, which shows that source and destination addressing advance together by the subvector length.
- A pattern that mixes copy, 0.0, 1.0 and untouched lanes, which separates the four selector classes.
- An in-place reversal with rd equal to rs1, which exposes any write that overtakes a pending read.
- A three-lane run whose fourth selector would inject 0.0, which shows that out-of-range lane selectors are ignored.
- A run at the top of the register file, which checks the modulo-64 wrap.
- An all-untouched run, during which `start`, the configuration and a test write are all disturbed mid-operation.

`busy` and `done` are compared on every cycle against the expected 2*L*V window. The whole register file is read back after each run.

// File: rtl/swz_pkg.sv
package swz_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 6;
    localparam int LANES   = 4;
    localparam int LANE_W  = $clog2(LANES);
    localparam int SEL_W   = 3;
    localparam int SWZ_W   = LANES * SEL_W;
    localparam int SVL_W   = 3;
    localparam int VL_W    = 4;

    localparam logic [DATA_W-1:0] FP_ZERO = 32'h0000_0000;
    localparam logic [DATA_W-1:0] FP_ONE  = 32'h3F80_0000;

    typedef enum logic [1:0] {
        K_COPY = 2'd0,
        K_ZERO = 2'd1,
        K_ONE  = 2'd2,
        K_KEEP = 2'd3
    } lane_kind_t;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_GATHER  = 2'd1,
        S_SCATTER = 2'd2,
        S_DONE    = 2'd3
    } seq_state_t;
endpackage

// File: rtl/swz_regfile.sv
module swz_regfile
    import swz_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
        end else if (we) begin
            slots[waddr] <= wdata;
        end
    end

    assign rdata_a = slots[raddr_a];
    assign rdata_b = slots[raddr_b];
endmodule

// File: rtl/swz_lane_decode.sv
module swz_lane_decode
    import swz_pkg::*;
#(
    parameter int NL = LANES,
    parameter int SW = SEL_W
) (
    input  logic [NL*SW-1:0]       swizzle,
    input  logic [$clog2(NL)-1:0]  lane,
    output logic [SW-1:0]          sel,
    output lane_kind_t             kind
);
    logic [SW-1:0] fields [NL];

    for (genvar g = 0; g < NL; g++) begin : g_field
        assign fields[g] = swizzle[g*SW +: SW];
    end

    always_comb begin
        sel = fields[lane];
        unique case (sel)
            3'd0, 3'd1, 3'd2, 3'd3: kind = K_COPY;
            3'd4:                   kind = K_ZERO;
            3'd5:                   kind = K_ONE;
            default:                kind = K_KEEP;
        endcase
    end
endmodule

// File: rtl/swz_seq.sv
module swz_seq
    import swz_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ADDR_W-1:0]   cfg_rd,
    input  logic [ADDR_W-1:0]   cfg_rs1,
    input  logic [SVL_W-1:0]    cfg_subvl,
    input  logic [VL_W-1:0]     cfg_vl,
    input  logic [SWZ_W-1:0]    cfg_swizzle,
    input  logic [SEL_W-1:0]    lane_sel,
    input  lane_kind_t          lane_kind,
    input  logic [DATA_W-1:0]   rf_rdata,
    output logic [LANE_W-1:0]   lane,
    output logic [SWZ_W-1:0]    swz_q,
    output logic [ADDR_W-1:0]   rf_raddr,
    output logic                rf_we,
    output logic [ADDR_W-1:0]   rf_waddr,
    output logic [DATA_W-1:0]   rf_wdata,
    output logic                busy,
    output logic                done,
    output logic                engaged
);
    seq_state_t state, state_nx;

    logic [ADDR_W-1:0] rd_q, rs1_q, elem_base;
    logic [SVL_W-1:0]  subvl_q;
    logic [VL_W-1:0]   vl_q, sub_idx;
    logic [DATA_W-1:0] lane_buf [LANES];
    logic              last_lane, last_sub;

    assign last_lane = ({1'b0, lane} == (subvl_q - 3'd1));
    assign last_sub  = (sub_idx == (vl_q - 4'd1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (start) state_nx = S_GATHER;
            S_GATHER:  if (last_lane) state_nx = S_SCATTER;
            S_SCATTER: if (last_lane) state_nx = last_sub ? S_DONE : S_GATHER;
            S_DONE:    state_nx = S_IDLE;
        endcase
    end

    // counters and captured configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q      <= '0;
            rs1_q     <= '0;
            subvl_q   <= 3'd1;
            vl_q      <= 4'd1;
            swz_q     <= '0;
            lane      <= '0;
            sub_idx   <= '0;
            elem_base <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        rd_q      <= cfg_rd;
                        rs1_q     <= cfg_rs1;
                        subvl_q   <= cfg_subvl;
                        vl_q      <= cfg_vl;
                        swz_q     <= cfg_swizzle;
                        lane      <= '0;
                        sub_idx   <= '0;
                        elem_base <= '0;
                    end
                end
                S_GATHER: begin
                    lane <= last_lane ? '0 : lane + 1'b1;
                end
                S_SCATTER: begin
                    lane <= last_lane ? '0 : lane + 1'b1;
                    if (last_lane) begin
                        sub_idx   <= sub_idx + 1'b1;
                        elem_base <= elem_base + ADDR_W'(subvl_q);
                    end
                end
                S_DONE: begin
                    lane <= '0;
                end
            endcase
        end
    end

    // lane buffer, one register per lane
    for (genvar g = 0; g < LANES; g++) begin : g_buf
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_buf[g] <= '0;
            else if (state == S_GATHER && lane == LANE_W'(g))
                lane_buf[g] <= rf_rdata;
        end
    end

    // outputs
    always_comb begin
        rf_raddr = rs1_q + elem_base + ADDR_W'(lane_sel[1:0]);
        rf_waddr = rd_q + elem_base + ADDR_W'(lane);
        rf_we    = 1'b0;
        rf_wdata = lane_buf[lane];
        busy     = 1'b0;
        done     = 1'b0;
        engaged  = 1'b1;
        unique case (state)
            S_IDLE:    engaged = 1'b0;
            S_GATHER:  busy = 1'b1;
            S_SCATTER: begin
                busy = 1'b1;
                unique case (lane_kind)
                    K_COPY: begin rf_we = 1'b1; rf_wdata = lane_buf[lane]; end
                    K_ZERO: begin rf_we = 1'b1; rf_wdata = FP_ZERO; end
                    K_ONE:  begin rf_we = 1'b1; rf_wdata = FP_ONE;  end
                    K_KEEP: rf_we = 1'b0;
                endcase
            end
            S_DONE:    done = 1'b1;
        endcase
    end

    // R10: completion pulse lasts one cycle and is followed by idle
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    // R10: a start taken in idle makes the unit busy on the next cycle
    assert_start_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start) |=> busy);
    // R7: the lane counter never walks past the programmed subvector length
    assert_lane_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ({1'b0, lane} < subvl_q));
    // R11: captured configuration holds steady while busy
    assert_cfg_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(swz_q) && $stable(rd_q) && $stable(rs1_q)));
endmodule

// File: rtl/swz_move_unit.sv
module swz_move_unit
    import swz_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ADDR_W-1:0]   cfg_rd,
    input  logic [ADDR_W-1:0]   cfg_rs1,
    input  logic [SVL_W-1:0]    cfg_subvl,
    input  logic [VL_W-1:0]     cfg_vl,
    input  logic [SWZ_W-1:0]    cfg_swizzle,
    output logic                busy,
    output logic                done,
    input  logic                tp_we,
    input  logic [ADDR_W-1:0]   tp_addr,
    input  logic [DATA_W-1:0]   tp_wdata,
    output logic [DATA_W-1:0]   tp_rdata
);
    logic [LANE_W-1:0] lane;
    logic [SWZ_W-1:0]  swz_q;
    logic [SEL_W-1:0]  lane_sel;
    lane_kind_t        lane_kind;
    logic [ADDR_W-1:0] seq_raddr, seq_waddr, rf_waddr;
    logic [DATA_W-1:0] seq_wdata, rf_wdata, rf_rdata_a;
    logic              seq_we, rf_we, engaged;

    swz_lane_decode #(.NL(LANES), .SW(SEL_W)) i_decode (
        .swizzle (swz_q),
        .lane    (lane),
        .sel     (lane_sel),
        .kind    (lane_kind)
    );

    swz_seq i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cfg_rd      (cfg_rd),
        .cfg_rs1     (cfg_rs1),
        .cfg_subvl   (cfg_subvl),
        .cfg_vl      (cfg_vl),
        .cfg_swizzle (cfg_swizzle),
        .lane_sel    (lane_sel),
        .lane_kind   (lane_kind),
        .rf_rdata    (rf_rdata_a),
        .lane        (lane),
        .swz_q       (swz_q),
        .rf_raddr    (seq_raddr),
        .rf_we       (seq_we),
        .rf_waddr    (seq_waddr),
        .rf_wdata    (seq_wdata),
        .busy        (busy),
        .done        (done),
        .engaged     (engaged)
    );

    // write-port arbitration: test writes only while idle
    always_comb begin
        if (engaged) begin
            rf_we    = seq_we;
            rf_waddr = seq_waddr;
            rf_wdata = seq_wdata;
        end else begin
            rf_we    = tp_we;
            rf_waddr = tp_addr;
            rf_wdata = tp_wdata;
        end
    end

    swz_regfile #(.DW(DATA_W), .AW(ADDR_W)) i_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (seq_raddr),
        .rdata_a (rf_rdata_a),
        .raddr_b (tp_addr),
        .rdata_b (tp_rdata)
    );

    // R2: while an operation runs, a test write never reaches the file
    assert_tp_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rf_we) |-> (rf_waddr == seq_waddr && rf_wdata == seq_wdata));
    // R5: a 1.0 selector produces the single-precision one pattern
    assert_const_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && seq_we && lane_kind == K_ONE) |-> (seq_wdata == 32'h3F80_0000));
    // R4: a 0.0 selector produces all-zero data
    assert_const_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && seq_we && lane_kind == K_ZERO) |-> (seq_wdata == '0));
    // R6: untouched selectors never open the write port
    assert_keep_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && lane_sel[2:1] == 2'b11) |-> !rf_we);
endmodule

// File: tb/test_swz_move_unit.sv
module test_swz_move_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  cfg_rd = '0, cfg_rs1 = '0;
    logic [2:0]  cfg_subvl = 3'd1;
    logic [3:0]  cfg_vl = 4'd1;
    logic [11:0] cfg_swizzle = '0;
    logic        busy, done;
    logic        tp_we = 1'b0;
    logic [5:0]  tp_addr = '0;
    logic [31:0] tp_wdata = '0;
    logic [31:0] tp_rdata;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] mdl [64];

    always #2 clk = ~clk;

    swz_move_unit i_swz_move_unit (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_rd(cfg_rd), .cfg_rs1(cfg_rs1), .cfg_subvl(cfg_subvl),
        .cfg_vl(cfg_vl), .cfg_swizzle(cfg_swizzle),
        .busy(busy), .done(done),
        .tp_we(tp_we), .tp_addr(tp_addr), .tp_wdata(tp_wdata), .tp_rdata(tp_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_all(input string req);
        for (int a = 0; a < 64; a++) begin
            @(negedge clk);
            tp_addr = 6'(a);
            #1;
            chk(req, tp_rdata, mdl[a]);
        end
    endtask

    task automatic tp_write(input int a, input logic [31:0] d);
        @(negedge clk);
        tp_we = 1'b1; tp_addr = 6'(a); tp_wdata = d;
        @(negedge clk);
        tp_we = 1'b0;
        mdl[a] = d;
    endtask

    // behavioural reference: gather then scatter per subvector
    task automatic model_op(input int rd, input int rs1, input int sv, input int vl,
                            input logic [11:0] swz);
        logic [31:0] tmp [4];
        for (int i = 0; i < vl; i++) begin
            for (int s = 0; s < sv; s++) begin
                int sel = int'(swz[3*s +: 3]);
                tmp[s] = (sel < 4) ? mdl[(rs1 + i*sv + sel) % 64] : 32'h0;
            end
            for (int s = 0; s < sv; s++) begin
                int sel = int'(swz[3*s +: 3]);
                int d = (rd + i*sv + s) % 64;
                if (sel < 4)       mdl[d] = tmp[s];
                else if (sel == 4) mdl[d] = 32'h0000_0000;
                else if (sel == 5) mdl[d] = 32'h3F80_0000;
            end
        end
    endtask

    task automatic run_op(input string req, input int rd, input int rs1, input int sv,
                          input int vl, input logic [11:0] swz, input bit disturb);
        int nb = 2*sv*vl;
        model_op(rd, rs1, sv, vl, swz);
        @(negedge clk);
        cfg_rd = 6'(rd); cfg_rs1 = 6'(rs1); cfg_subvl = 3'(sv);
        cfg_vl = 4'(vl); cfg_swizzle = swz; start = 1'b1;
        for (int c = 1; c <= nb + 2; c++) begin
            @(negedge clk);
            start = 1'b0;
            tp_we = 1'b0;
            chk({req, " R10 busy"}, 32'(busy), 32'(c <= nb));
            chk({req, " R10 done"}, 32'(done), 32'(c == nb + 1));
            if (disturb && c == 3) begin
                // R10 start ignored, R11 config change ignored, R2 test write ignored
                start = 1'b1;
                cfg_rd = 6'd0; cfg_subvl = 3'd4; cfg_vl = 4'd8; cfg_swizzle = 12'o4444;
                tp_we = 1'b1; tp_addr = 6'd63; tp_wdata = 32'hDEAD_BEEF;
            end
        end
        read_all(req);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int a = 0; a < 64; a++) mdl[a] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", 32'(busy), 32'h0);
        chk("R1 done", 32'(done), 32'h0);
        read_all("R1 regs");
        // R2 load a pattern through the test port and read it back
        for (int a = 0; a < 64; a++) tp_write(a, 32'h1000_0000 + 32'(a) * 32'h111);
        read_all("R2 readback");
        // R3 R8 identity swizzle: lane s takes selector s
        run_op("R3 R8 identity", 20, 0, 4, 2, {3'd3, 3'd2, 3'd1, 3'd0}, 1'b0);
        // R4 R5 R6 mixed classes: lane0 0.0, lane1 1.0, lane2 untouched, lane3 copy
        run_op("R4 R5 R6 mixed", 32, 4, 4, 3, {3'd3, 3'd6, 3'd5, 3'd4}, 1'b0);
        // R9 in-place reversal with rd == rs1
        run_op("R9 inplace", 8, 8, 4, 2, {3'd0, 3'd1, 3'd2, 3'd3}, 1'b0);
        // R7 three lanes, fourth selector (0.0) must be ignored
        run_op("R7 subvl3", 44, 10, 3, 5, {3'd4, 3'd0, 3'd2, 3'd1}, 1'b0);
        // R8 wrap at the top of the file
        run_op("R8 wrap", 62, 60, 2, 4, {3'd7, 3'd7, 3'd0, 3'd1}, 1'b0);
        // R6 R10 R11 R2 nothing written while disturbed mid-run
        run_op("R2 R6 R11 disturb", 0, 0, 1, 8, 12'o7777, 1'b1);
        // R5 R6 single subvector, lane0 1.0 and lane1 untouched (selector 6)
        run_op("R5 R6 short", 30, 0, 2, 1, {3'd0, 3'd0, 3'd6, 3'd5}, 1'b0);
        // R2 a test write after the run is accepted again
        tp_write(63, 32'h0BAD_F00D);
        read_all("R2 idle write");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule